// File: doc/BRIEF.md
# Dual-Edge PDM Capture

This block receives one pulse-density-modulated data line that carries two one-bit channels, one on each phase of the PDM bit clock. It samples the line on both clock edges and pairs the two samples. The channel taken on the selected primary edge becomes channel A. The sample from the opposite edge that follows it becomes channel B. Each completed A/B pair is handed from the PDM clock domain to the system clock domain. The PDM clock has no fixed phase relation to the system clock. The crossing uses a toggle request/acknowledge handshake, with both toggles passed through multi-flop synchronizers.

In the system domain, a route input sends each pair to one of two valid/ready stream ports: a sensor port or a playback port. A port holds its pair and keeps valid high until its consumer takes the pair. While a port is stalled, the crossing register stays occupied, and pairs completed on the PDM side in that time are discarded. A pair that has already been captured is never overwritten. A clock-source input can tie the sampling clock to ground, which stops all capture.

Top module: `pdm_dual_capture`

## Requirements
- R1: With `cfg_edge_fall` = 0, channel A is the line value sampled on a rising clock edge, and channel B is the value sampled on the next falling edge.
- R2: With `cfg_edge_fall` = 1, channel A is the value sampled on a falling edge, and channel B is the value sampled on the next rising edge.
- R3: A pair is presented on the sensor port when `cfg_route_play` = 0 at hand-off, and on the playback port when it is 1. A port's valid rises only for pairs routed to it.
- R4: While a port's valid is high and its ready is low, valid stays high and its channel outputs stay unchanged.
- R5: A pair is transferred on a clock edge where valid and ready are both high. If no further pair is waiting, valid is low on the following cycle.
- R6: A captured pair is held in the crossing register until the system side has taken it. Pairs that complete meanwhile are discarded. Delivered pairs always appear in capture order and are never corrupted.
- R7: Assume the selected ready is held high, the system clock is at least eight times the bit clock, and each pair value stays on the line for at least four bit periods. Under these conditions, every pair value is delivered, in order.
- R8: With `cfg_clk_from_pin` = 0 (sampling clock grounded), toggling the clock pin produces no valid, and both ports' channel outputs hold their values.
- R9: After a synchronous active-high `sys_rst` (with at least two bit-clock edges during it), both valids are low and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| pdm_clk_pin | input | 1 | External PDM bit clock |
| pdm_data | input | 1 | PDM data line, two channels interleaved |
| cfg_edge_fall | input | 1 | Primary edge: 0 rising, 1 falling |
| cfg_clk_from_pin | input | 1 | Sampling clock: 1 clock pin, 0 ground |
| cfg_route_play | input | 1 | Route: 0 sensor port, 1 playback port |
| sens_valid | output | 1 | Sensor port pair valid |
| sens_ready | input | 1 | Sensor port consumer ready |
| sens_ch_a | output | 1 | Sensor port channel A |
| sens_ch_b | output | 1 | Sensor port channel B |
| play_valid | output | 1 | Playback port pair valid |
| play_ready | input | 1 | Playback port consumer ready |
| play_ch_a | output | 1 | Playback port channel A |
| play_ch_b | output | 1 | Playback port channel B |

## Verification
The hardest situation to reach from the ports is the crossing register being occupied while the PDM side keeps completing pairs that must be dropped. Reaching it needs back-pressure held across several round trips of the handshake. The bench generates the PDM clock itself, edge by edge, and places each channel value just before the edge that must sample it. It holds every pair value for four bit periods, so a lossless run predicts exactly which values arrive. It then stalls ready in the middle of a stream. During the stall it checks that the held pair is stable, and afterwards that the delivered values form an in-order subsequence of the values sent.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  typedef struct packed {
    logic ch_a;
    logic ch_b;
  } pdm_pair_t;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } pdm_edge_e;

  typedef enum logic {
    ROUTE_SENSOR = 1'b0,
    ROUTE_PLAY   = 1'b1
  } pdm_route_e;

  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/pdm_bit_sync.sv
module pdm_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler
  import pdm_cap_pkg::*;
(
  input  logic      pclk,
  input  logic      prst,
  input  logic      pdm_din,
  input  logic      edge_sel,
  output logic      pair_stb,
  output pdm_pair_t pair
);
  logic rise_q;
  logic fall_q;
  logic primed;

  // Sample taken on the falling phase of the bit clock.
  always_ff @(negedge pclk) begin
    if (prst) fall_q <= 1'b0;
    else      fall_q <= pdm_din;
  end

  // Sample taken on the rising phase; primed marks that history exists.
  always_ff @(posedge pclk) begin
    if (prst) begin
      rise_q <= 1'b0;
      primed <= 1'b0;
    end else begin
      rise_q <= pdm_din;
      primed <= 1'b1;
    end
  end

  // A pair completes at every rising edge once primed:
  // rising primary pairs the previous rising sample with the falling one
  // after it; falling primary pairs the falling sample with the live line.
  always_comb begin
    pair_stb = primed;
    if (edge_sel == EDGE_FALL) begin
      pair.ch_a = fall_q;
      pair.ch_b = pdm_din;
    end else begin
      pair.ch_a = rise_q;
      pair.ch_b = fall_q;
    end
  end
endmodule

// File: rtl/pdm_xfer_src.sv
module pdm_xfer_src
  import pdm_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      pclk,
  input  logic      prst,
  input  logic      pair_stb,
  input  pdm_pair_t pair,
  input  logic      ack_tgl,
  output logic      req_tgl,
  output pdm_pair_t pair_hold
);
  logic ack_s;
  logic idle;

  pdm_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (pclk),
    .d   (ack_tgl),
    .q   (ack_s)
  );

  assign idle = (req_tgl == ack_s);

  always_ff @(posedge pclk) begin
    if (prst) begin
      req_tgl   <= 1'b0;
      pair_hold <= '0;
    end else if (pair_stb && idle) begin
      pair_hold <= pair;
      req_tgl   <= ~req_tgl;
    end
  end

  // R6: an outstanding pair is never overwritten before acknowledge.
  a_r6_hold_while_busy: assert property (@(posedge pclk) disable iff (prst)
    (req_tgl != ack_s) |=> $stable(pair_hold));
endmodule

// File: rtl/pdm_xfer_dst.sv
module pdm_xfer_dst
  import pdm_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORTS       = NUM_PORTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_tgl,
  input  logic             route,
  input  logic [PORTS-1:0] take_ok,
  output logic [PORTS-1:0] load,
  output logic             ack_tgl
);
  logic req_s;
  logic seen;
  logic pending;
  logic go;

  pdm_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk),
    .d   (req_tgl),
    .q   (req_s)
  );

  assign pending = (req_s != seen);
  assign go      = pending && take_ok[route];

  always_comb begin
    load = '0;
    if (go) load[route] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     seen <= 1'b0;
    else if (go) seen <= req_s;
  end

  assign ack_tgl = seen;
endmodule

// File: rtl/pdm_stream_port.sv
module pdm_stream_port
  import pdm_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  pdm_pair_t load_pair,
  input  logic      ready,
  output logic      valid,
  output pdm_pair_t data,
  output logic      take_ok
);
  assign take_ok = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_pair;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R4: a stalled pair stays presented and unchanged.
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/pdm_dual_capture.sv
module pdm_dual_capture
  import pdm_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic pdm_clk_pin,
  input  logic pdm_data,
  input  logic cfg_edge_fall,
  input  logic cfg_clk_from_pin,
  input  logic cfg_route_play,
  output logic sens_valid,
  input  logic sens_ready,
  output logic sens_ch_a,
  output logic sens_ch_b,
  output logic play_valid,
  input  logic play_ready,
  output logic play_ch_a,
  output logic play_ch_b
);
  localparam int NPORT = NUM_PORTS;

  logic      pclk_eff;
  logic      prst;
  logic      pair_stb;
  pdm_pair_t pair_now;
  pdm_pair_t pair_hold;
  logic      req_tgl;
  logic      ack_tgl;

  logic [NPORT-1:0] port_load;
  logic [NPORT-1:0] port_take_ok;
  logic [NPORT-1:0] port_valid;
  logic [NPORT-1:0] port_ready;
  pdm_pair_t        port_data [NPORT];

  // Grounded source stops every edge in the capture domain.
  assign pclk_eff = pdm_clk_pin & cfg_clk_from_pin;

  pdm_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (pclk_eff),
    .d   (sys_rst),
    .q   (prst)
  );

  pdm_edge_sampler u_sampler (
    .pclk     (pclk_eff),
    .prst     (prst),
    .pdm_din  (pdm_data),
    .edge_sel (cfg_edge_fall),
    .pair_stb (pair_stb),
    .pair     (pair_now)
  );

  pdm_xfer_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .pclk      (pclk_eff),
    .prst      (prst),
    .pair_stb  (pair_stb),
    .pair      (pair_now),
    .ack_tgl   (ack_tgl),
    .req_tgl   (req_tgl),
    .pair_hold (pair_hold)
  );

  pdm_xfer_dst #(.SYNC_STAGES(SYNC_STAGES), .PORTS(NPORT)) u_dst (
    .clk     (sys_clk),
    .rst     (sys_rst),
    .req_tgl (req_tgl),
    .route   (cfg_route_play),
    .take_ok (port_take_ok),
    .load    (port_load),
    .ack_tgl (ack_tgl)
  );

  assign port_ready[ROUTE_SENSOR] = sens_ready;
  assign port_ready[ROUTE_PLAY]   = play_ready;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    pdm_stream_port u_port (
      .clk       (sys_clk),
      .rst       (sys_rst),
      .load      (port_load[gi]),
      .load_pair (pair_hold),
      .ready     (port_ready[gi]),
      .valid     (port_valid[gi]),
      .data      (port_data[gi]),
      .take_ok   (port_take_ok[gi])
    );
  end

  assign sens_valid = port_valid[ROUTE_SENSOR];
  assign sens_ch_a  = port_data[ROUTE_SENSOR].ch_a;
  assign sens_ch_b  = port_data[ROUTE_SENSOR].ch_b;
  assign play_valid = port_valid[ROUTE_PLAY];
  assign play_ch_a  = port_data[ROUTE_PLAY].ch_a;
  assign play_ch_b  = port_data[ROUTE_PLAY].ch_b;

  // R3: a port's valid rises only when the route selected it.
  a_r3_play_route: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $rose(play_valid) |-> $past(cfg_route_play));
  a_r3_sens_route: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $rose(sens_valid) |-> !$past(cfg_route_play));

  // R6: the capture side is released only once a port holds the pair.
  a_r6_ack_after_load: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !$stable(ack_tgl) |-> (sens_valid || play_valid));

  // R9: reset leaves both ports empty and cleared.
  a_r9_reset_clear: assert property (@(posedge sys_clk)
    $past(sys_rst) |-> (!sens_valid && !play_valid && !sens_ch_a && !sens_ch_b
                        && !play_ch_a && !play_ch_b));
endmodule

// File: tb/tb_pdm_dual_capture.sv
module tb_pdm_dual_capture;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 20;   // quarter bit period: bit clock = 8 system clocks

  logic sys_clk = 1'b0;
  logic sys_rst = 1'b1;
  logic pclk = 1'b0;
  logic pdat = 1'b0;
  logic edge_fall = 1'b0;
  logic src_pin = 1'b1;
  logic route = 1'b0;
  logic s_rdy = 1'b1;
  logic p_rdy = 1'b1;
  logic sens_valid, sens_a, sens_b, play_valid, play_a, play_b;

  int checks = 0;
  int fails = 0;
  logic [1:0] exp_q [$];
  logic [1:0] last_v;
  bit   have_last = 1'b0;
  bit   lossy = 1'b0;
  int   lossy_hits = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  pdm_dual_capture dut (
    .sys_clk          (sys_clk),
    .sys_rst          (sys_rst),
    .pdm_clk_pin      (pclk),
    .pdm_data         (pdat),
    .cfg_edge_fall    (edge_fall),
    .cfg_clk_from_pin (src_pin),
    .cfg_route_play   (route),
    .sens_valid       (sens_valid),
    .sens_ready       (s_rdy),
    .sens_ch_a        (sens_a),
    .sens_ch_b        (sens_b),
    .play_valid       (play_valid),
    .play_ready       (p_rdy),
    .play_ch_a        (play_a),
    .play_ch_b        (play_b)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One bit period: value a lands on the primary edge, b on the other edge.
  task automatic bit_cycle(input logic a, input logic b);
    if (!edge_fall) begin
      pdat = a; #QTR; pclk = 1'b1; #QTR;
      pdat = b; #QTR; pclk = 1'b0; #QTR;
    end else begin
      pdat = a; #QTR; pclk = 1'b0; #QTR;
      pdat = b; #QTR; pclk = 1'b1; #QTR;
    end
  endtask

  task automatic set_edge(input logic fall);
    pdat = 1'b0;
    if (fall && !edge_fall) begin
      edge_fall = 1'b1; #QTR; pclk = 1'b1; #QTR;
    end else if (!fall && edge_fall) begin
      #QTR; pclk = 1'b0; #QTR; edge_fall = 1'b0;
    end
  endtask

  // Driver: pushes each distinct pair value, held four bit periods.
  task automatic run_stream(input int n, input int seed);
    have_last = 1'b0;
    for (int f = 0; f < 3; f++) bit_cycle(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [1:0] v;
      v = 2'(((i * 2 + seed) % 3) + 1);
      exp_q.push_back(v);
      for (int h = 0; h < 4; h++) bit_cycle(v[1], v[0]);
    end
    for (int f = 0; f < 3; f++) bit_cycle(1'b0, 1'b0);
    repeat (40) @(posedge sys_clk);
  endtask

  // Monitor: pops and compares each transferred pair.
  task automatic take(input bit is_play, input logic [1:0] v);
    if (v == 2'b00) return;
    check(is_play == route, "R3", "delivery port", int'(is_play), int'(route));
    if (have_last && v == last_v) return;
    if (lossy) begin
      while (exp_q.size() > 0 && exp_q[0] != v) void'(exp_q.pop_front());
      check(exp_q.size() > 0, "R6", "pair in capture order", int'(v), 0);
      if (exp_q.size() > 0) begin
        last_v = exp_q.pop_front(); have_last = 1'b1; lossy_hits++;
      end
    end else begin
      check(exp_q.size() > 0 && exp_q[0] == v, cur_req, "pair value",
            int'(v), exp_q.size() > 0 ? int'(exp_q[0]) : -1);
      if (exp_q.size() > 0) begin
        last_v = exp_q.pop_front(); have_last = 1'b1;
      end
    end
  endtask

  always @(negedge sys_clk) begin
    if (!sys_rst) begin
      if (sens_valid && s_rdy) take(1'b0, {sens_a, sens_b});
      if (play_valid && p_rdy) take(1'b1, {play_a, play_b});
    end
  end

  task automatic end_of_stream(input string req);
    check(exp_q.size() == 0, req, "pairs left undelivered", exp_q.size(), 0);
    @(negedge sys_clk);
    check(!sens_valid && !play_valid, "R5", "valid after last take",
          int'({sens_valid, play_valid}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] hold_s, hold_p;
    bit stall_ok;
    bit saw_valid;
    // Reset with bit-clock edges so the capture domain clears too.
    for (int i = 0; i < 6; i++) bit_cycle(1'b0, 1'b0);
    @(posedge sys_clk); #2 sys_rst = 1'b0;
    repeat (3) @(negedge sys_clk);
    check(!sens_valid, "R9", "sens_valid after reset", int'(sens_valid), 0);
    check(!play_valid, "R9", "play_valid after reset", int'(play_valid), 0);
    check({sens_a, sens_b} == 2'b00, "R9", "sensor data after reset", int'({sens_a, sens_b}), 0);
    check({play_a, play_b} == 2'b00, "R9", "playback data after reset", int'({play_a, play_b}), 0);

    // R1 rising primary to sensor port
    cur_req = "R1"; route = 1'b0;
    run_stream(12, 0);
    end_of_stream("R7");

    // R2 falling primary to playback port (R3 routing)
    set_edge(1'b1);
    cur_req = "R2"; route = 1'b1;
    run_stream(12, 1);
    end_of_stream("R7");

    // R1 again, back on the sensor port with another pattern
    set_edge(1'b0);
    cur_req = "R1"; route = 1'b0;
    run_stream(10, 2);
    end_of_stream("R7");

    // R8 grounded sampling clock
    hold_s = {sens_a, sens_b};
    hold_p = {play_a, play_b};
    src_pin = 1'b0;
    saw_valid = 1'b0;
    fork
      for (int i = 0; i < 20; i++) bit_cycle(1'(i % 2), 1'b1);
      repeat (180) begin
        @(negedge sys_clk);
        if (sens_valid || play_valid) saw_valid = 1'b1;
      end
    join
    repeat (40) @(negedge sys_clk);
    if (sens_valid || play_valid) saw_valid = 1'b1;
    check(!saw_valid, "R8", "valid with grounded clock", int'(saw_valid), 0);
    check({sens_a, sens_b} == hold_s, "R8", "sensor data held", int'({sens_a, sens_b}), int'(hold_s));
    check({play_a, play_b} == hold_p, "R8", "playback data held", int'({play_a, play_b}), int'(hold_p));
    src_pin = 1'b1;

    // R4 / R6 back-pressure on the sensor port
    lossy = 1'b1; lossy_hits = 0;
    @(posedge sys_clk); #2 s_rdy = 1'b0;
    stall_ok = 1'b1;
    fork
      run_stream(16, 0);
      begin
        int guard;
        guard = 0;
        do begin @(negedge sys_clk); guard++; end while (!sens_valid && guard < 2000);
        hold_s = {sens_a, sens_b};
        repeat (150) begin
          @(negedge sys_clk);
          if (!sens_valid || {sens_a, sens_b} != hold_s) stall_ok = 1'b0;
        end
        check(stall_ok && guard < 2000, "R4", "pair held under stall", int'(stall_ok), 1);
        @(posedge sys_clk); #2 s_rdy = 1'b1;
      end
    join
    check(lossy_hits >= 2, "R6", "pairs delivered after stall", lossy_hits, 2);
    exp_q.delete();
    lossy = 1'b0;
    @(negedge sys_clk);
    check(!sens_valid && !play_valid, "R5", "valid after drain",
          int'({sens_valid, play_valid}), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule